// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a single-bank SDRAM device refreshed and serialises the refresh with single-word host reads. A programmable down-counter sets the refresh period. Each time it expires, the block records a refresh as owed. When the command sequencer is free, it precharges all banks, waits out the precharge time and issues an auto-refresh. The device steps its own internal refresh row, so no refresh address comes from this block. The sequencer then holds the bus quiet for the refresh cycle time before it accepts new work.

A host read is a level request with a row/column address. The host keeps the request asserted while the wait output is high. The cycle in which wait is low is the cycle in which the activate command goes out, and the host may then drop the request. The read issues activate, then a read with auto-precharge, captures the data word after the CAS latency and returns it with a one-cycle valid strobe. If a refresh period runs out while the previous refresh is still owed, a sticky error interrupt is raised. A read of the two-bit status port clears it. A period value of zero stops refresh generation altogether.

Top module: `sdram_refresh_sched`

## Requirements
- R1: The SDRAM command appears on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n` as 0111 for no-operation (also the reset and idle value), 0010 for precharge, 0001 for auto-refresh, 0011 for activate and 0101 for read.
- R2: With a nonzero period N of at least 12 and no host traffic, successive precharge commands of the refresh sequence are exactly N cycles apart.
- R3: A refresh precharge drives sd_addr bit 10 high. The auto-refresh follows it exactly T_RP (3) cycles later. No activate is issued earlier than T_RC (8) cycles after an auto-refresh.
- R4: A period value of zero produces no refresh commands and no error.
- R5: When the period expires while the previous refresh has not yet started, ref_irq and status bit 0 go high and stay high until a status read. With a period of 12 or more this never happens; with 11 or less it eventually does.
- R6: In the cycle after a stat_rd pulse with no new expiry, ref_irq is low. The status value is readable in the cycle of the pulse.
- R7: A read issues activate with the row (host_addr bits above the column field) on sd_addr. The read command follows T_RCD (3) cycles later, with the column (host_addr low COL_W bits) on sd_addr and bit 10 high. sd_dq is sampled CAS_LAT (2) cycles after the read command. host_rvalid and the word appear one cycle after that.
- R8: host_wait is high in every cycle in which host_req is high and no activate is issued for it. It is low in the activate cycle. A request arriving at an idle block with no refresh owed gets its activate in the same cycle.
- R9: After a read, the next activate is issued no earlier than T_RP cycles after host_rvalid, so back-to-back requests are activated 9 cycles apart.
- R10: An owed refresh wins over a waiting host request. A read already activated completes before the refresh precharge.
- R11: Status bit 1 is high while a refresh sequence (precharge through the end of the refresh cycle time) is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | TW | Refresh period in clocks; zero disables refresh |
| host_req | input | 1 | Read request, held until wait is low |
| host_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| host_wait | output | 1 | Request cannot be accepted this cycle |
| host_rvalid | output | 1 | Read data valid strobe |
| host_rdata | output | DW | Read data word |
| stat_rd | input | 1 | Status read strobe; clears the error flag |
| stat_rdata | output | 2 | {refresh busy, refresh error} |
| ref_irq | output | 1 | Sticky refresh-error interrupt |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | AW | SDRAM address bus |
| sd_dq | input | DW | SDRAM read data |

## Verification
The refresh period is swept over several values at and above the 12-cycle sequence length. This shows exact spacing, and it shows that the error stays silent at the boundary. Periods of 11 and 6 show that a backlog raises the sticky flag and that only a status read clears it. Reads are swept over rows and columns that include the all-ones extremes, with a data model that returns an address-derived word only in the single cycle the CAS latency allows. That separates a correct capture cycle from one a cycle early or late. Requests are also placed in the middle of a refresh, just ahead of a period expiry and back to back, which distinguishes the wait release, the refresh priority and the recovery spacing.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

   // command on {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_PRE = 4'b0010,
      CMD_REF = 4'b0001,
      CMD_ACT = 4'b0011,
      CMD_RD  = 4'b0101
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_PRE_WAIT,
      ST_REF,
      ST_REF_WAIT,
      ST_RCD_WAIT,
      ST_READ,
      ST_CAS_WAIT,
      ST_RECOVER
   } seq_st_e;

   // address bit that selects all-bank precharge / auto-precharge
   localparam int ALLBANK_BIT = 10;

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] interval,
   output logic          tick
);

   logic [TW-1:0] cnt;
   logic          off;

   assign off  = (interval == '0);
   assign tick = !off && (cnt == TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (off) begin
         cnt <= '0;
      end else if (cnt == '0 || cnt == TW'(1)) begin
         cnt <= interval;
      end else begin
         cnt <= cnt - TW'(1);
      end
   end

endmodule

// File: rtl/sdr_ref_tracker.sv
module sdr_ref_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic stat_rd,
   output logic want,
   output logic err
);

   logic pend;

   assign want = pend | tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         err  <= 1'b0;
      end else begin
         // a start consumes the owed refresh; an expiry in the same cycle
         // on top of an already owed one stays owed
         pend <= start ? (tick & pend) : (pend | tick);
         if (tick && pend && !start)
            err <= 1'b1;
         else if (stat_rd)
            err <= 1'b0;
      end
   end

   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !stat_rd) |=> err);

   assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tick) |=> !err);

endmodule

// File: rtl/sdr_ref_seq.sv
module sdr_ref_seq
   import sdr_ref_pkg::*;
#(
   parameter int  DW         = 16,
   parameter int  ROW_W      = 13,
   parameter int  COL_W      = 9,
   parameter int  AW         = 13,
   parameter int  T_RP       = 3,
   parameter int  T_RC       = 8,
   parameter int  T_RCD      = 3,
   parameter int  CAS_LAT    = 2,
   parameter bit  HOLD_RDATA = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ref_want,
   input  logic                   host_req,
   input  logic [ROW_W+COL_W-1:0] host_addr,
   input  logic [DW-1:0]          sd_dq,
   output sdr_cmd_e               cmd,
   output logic [AW-1:0]          sd_addr,
   output logic                   host_wait,
   output logic                   host_rvalid,
   output logic [DW-1:0]          host_rdata,
   output logic                   ref_start,
   output logic                   ref_busy
);

   localparam int M1   = (T_RC > T_RP) ? T_RC : T_RP;
   localparam int M2   = (T_RCD > CAS_LAT) ? T_RCD : CAS_LAT;
   localparam int MAXW = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXW + 1);

   localparam logic [CW-1:0] LD_PREW  = CW'(T_RP - 2);
   localparam logic [CW-1:0] LD_REFW  = CW'(T_RC - 2);
   localparam logic [CW-1:0] LD_RCDW  = CW'(T_RCD - 2);
   localparam logic [CW-1:0] LD_CASW  = CW'(CAS_LAT - 1);
   localparam logic [CW-1:0] LD_RECOV = CW'(T_RP - 1);

   seq_st_e            state, nxt;
   logic [CW-1:0]      wcnt, wld;
   logic [COL_W-1:0]   col_q;
   logic [ROW_W-1:0]   req_row;
   logic [COL_W-1:0]   req_col;
   logic               act_now;
   logic               cap;

   assign req_row = host_addr[ROW_W+COL_W-1:COL_W];
   assign req_col = host_addr[COL_W-1:0];

   always_comb begin
      nxt       = state;
      cmd       = CMD_NOP;
      sd_addr   = '0;
      ref_start = 1'b0;
      act_now   = 1'b0;
      case (state)
         ST_IDLE: begin
            if (ref_want) begin
               ref_start = 1'b1;
               nxt       = ST_PRE;
            end else if (host_req) begin
               act_now = 1'b1;
               cmd     = CMD_ACT;
               sd_addr = AW'(req_row);
               nxt     = ST_RCD_WAIT;
            end
         end
         ST_PRE: begin
            cmd                  = CMD_PRE;
            sd_addr[ALLBANK_BIT] = 1'b1;
            nxt                  = ST_PRE_WAIT;
         end
         ST_PRE_WAIT: if (wcnt == '0) nxt = ST_REF;
         ST_REF: begin
            cmd = CMD_REF;
            nxt = ST_REF_WAIT;
         end
         ST_REF_WAIT: if (wcnt == '0) nxt = ST_IDLE;
         ST_RCD_WAIT: if (wcnt == '0) nxt = ST_READ;
         ST_READ: begin
            cmd                  = CMD_RD;
            sd_addr              = AW'(col_q);
            sd_addr[ALLBANK_BIT] = 1'b1;
            nxt                  = ST_CAS_WAIT;
         end
         ST_CAS_WAIT: if (wcnt == '0) nxt = ST_RECOVER;
         ST_RECOVER:  if (wcnt == '0) nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      case (nxt)
         ST_PRE_WAIT: wld = LD_PREW;
         ST_REF_WAIT: wld = LD_REFW;
         ST_RCD_WAIT: wld = LD_RCDW;
         ST_CAS_WAIT: wld = LD_CASW;
         ST_RECOVER:  wld = LD_RECOV;
         default:     wld = '0;
      endcase
   end

   assign host_wait = host_req && !act_now;
   assign ref_busy  = (state == ST_PRE) || (state == ST_PRE_WAIT) ||
                      (state == ST_REF) || (state == ST_REF_WAIT);
   assign cap       = (state == ST_CAS_WAIT) && (wcnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         wcnt  <= '0;
         col_q <= '0;
      end else begin
         state <= nxt;
         if (nxt != state)
            wcnt <= wld;
         else if (wcnt != '0)
            wcnt <= wcnt - CW'(1);
         if (act_now)
            col_q <= req_col;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) host_rvalid <= 1'b0;
      else        host_rvalid <= cap;
   end

   generate
      if (HOLD_RDATA) begin : g_rdata_hold
         always_ff @(posedge clk) begin
            if (!rst_n)   host_rdata <= '0;
            else if (cap) host_rdata <= sd_dq;
         end
      end else begin : g_rdata_zero
         always_ff @(posedge clk) begin
            if (!rst_n) host_rdata <= '0;
            else        host_rdata <= cap ? sd_dq : '0;
         end
      end
   endgenerate

   // cycle distances between commands, kept apart from the sequencer counter
   logic [7:0] since_pre, since_ref, since_act, since_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_pre <= 8'hFF;
         since_ref <= 8'hFF;
         since_act <= 8'hFF;
         since_rd  <= 8'hFF;
      end else begin
         since_pre <= (cmd == CMD_PRE) ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
         since_ref <= (cmd == CMD_REF) ? 8'd1 : (since_ref == 8'hFF ? since_ref : since_ref + 8'd1);
         since_act <= (cmd == CMD_ACT) ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
         since_rd  <= (cmd == CMD_RD)  ? 8'd1 : (since_rd  == 8'hFF ? since_rd  : since_rd  + 8'd1);
      end
   end

   assert_pre_to_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REF) |-> (since_pre == 8'(T_RP)));

   assert_trc_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> (since_ref >= 8'(T_RC)));

   assert_rcd_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD) |-> (since_act == 8'(T_RCD)));

   assert_rvalid_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> (since_rd == 8'(CAS_LAT + 1)));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import sdr_ref_pkg::*;
#(
   parameter int TW         = 16,
   parameter int DW         = 16,
   parameter int ROW_W      = 13,
   parameter int COL_W      = 9,
   parameter int AW         = 13,
   parameter int T_RP       = 3,
   parameter int T_RC       = 8,
   parameter int T_RCD      = 3,
   parameter int CAS_LAT    = 2,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TW-1:0]          cfg_interval,
   input  logic                   host_req,
   input  logic [ROW_W+COL_W-1:0] host_addr,
   output logic                   host_wait,
   output logic                   host_rvalid,
   output logic [DW-1:0]          host_rdata,
   input  logic                   stat_rd,
   output logic [1:0]             stat_rdata,
   output logic                   ref_irq,
   output logic                   sd_cs_n,
   output logic                   sd_ras_n,
   output logic                   sd_cas_n,
   output logic                   sd_we_n,
   output logic [AW-1:0]          sd_addr,
   input  logic [DW-1:0]          sd_dq
);

   generate
      if (T_RP < 2 || T_RC < 2 || T_RCD < 2 || CAS_LAT < 1) begin : g_bad_timing
         $error("sdram_refresh_sched: T_RP, T_RC, T_RCD must be >= 2 and CAS_LAT >= 1");
      end
      if (T_RP > 200 || T_RC > 200 || T_RCD > 200 || CAS_LAT > 200) begin : g_big_timing
         $error("sdram_refresh_sched: timing values must stay below 200");
      end
      if (AW <= ALLBANK_BIT || ROW_W > AW || COL_W > ALLBANK_BIT) begin : g_bad_addr
         $error("sdram_refresh_sched: address widths incompatible with bit 10 usage");
      end
      if (TW < 2 || DW < 1) begin : g_bad_width
         $error("sdram_refresh_sched: TW must be >= 2 and DW >= 1");
      end
   endgenerate

   logic     tick, want, start, busy, err;
   sdr_cmd_e cmd;

   sdr_ref_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .interval (cfg_interval),
      .tick     (tick)
   );

   sdr_ref_tracker u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .start   (start),
      .stat_rd (stat_rd),
      .want    (want),
      .err     (err)
   );

   sdr_ref_seq #(
      .DW         (DW),
      .ROW_W      (ROW_W),
      .COL_W      (COL_W),
      .AW         (AW),
      .T_RP       (T_RP),
      .T_RC       (T_RC),
      .T_RCD      (T_RCD),
      .CAS_LAT    (CAS_LAT),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_want    (want),
      .host_req    (host_req),
      .host_addr   (host_addr),
      .sd_dq       (sd_dq),
      .cmd         (cmd),
      .sd_addr     (sd_addr),
      .host_wait   (host_wait),
      .host_rvalid (host_rvalid),
      .host_rdata  (host_rdata),
      .ref_start   (start),
      .ref_busy    (busy)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign stat_rdata = {busy, err};
   assign ref_irq    = err;

endmodule

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cfg_interval;
   logic        host_req;
   logic [21:0] host_addr;
   logic        host_wait, host_rvalid;
   logic [15:0] host_rdata;
   logic        stat_rd;
   logic [1:0]  stat_rdata;
   logic        ref_irq;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [12:0] sd_addr;
   logic [15:0] sd_dq;
   logic [3:0]  cmd_b;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   int pre_cnt = 0;
   int last_pre = -100, last_ref = -100, last_act = -100, last_rd = -100, last_rv = -100;
   logic        pre_a10;
   logic [12:0] m_row, m_col;
   logic [15:0] last_rvd;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign cmd_b = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   sdram_refresh_sched uut (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
      .host_req(host_req), .host_addr(host_addr), .host_wait(host_wait),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata),
      .stat_rd(stat_rd), .stat_rdata(stat_rdata), .ref_irq(ref_irq),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_addr(sd_addr), .sd_dq(sd_dq)
   );

   function automatic logic [15:0] exp_data(input int row, input int col);
      return 16'(row * 37 + col * 11 + 4660);
   endfunction

   // device model and event recorder, sampling mid-cycle
   always @(negedge clk) begin
      #2;
      case (cmd_b)
         4'b0010: begin pre_cnt++; last_pre = cyc; pre_a10 = sd_addr[10]; end
         4'b0001: last_ref = cyc;
         4'b0011: begin last_act = cyc; m_row = sd_addr; end
         4'b0101: begin last_rd = cyc; m_col = sd_addr; end
         default: ;
      endcase
      if (host_rvalid) begin last_rv = cyc; last_rvd = host_rdata; end
      sd_dq = (cyc == last_rd + 2) ? exp_data(int'(m_row), int'(m_col[8:0])) : 16'hDEAD;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_cmd(input logic [3:0] code, input int limit, output int at);
      at = -1;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk); #3;
         if (cmd_b == code) begin at = cyc; break; end
      end
   endtask

   // runs until cycle fin, dropping the request after its activate
   task automatic hold_req(input int fin, output int waits);
      waits = 0;
      while (cyc < fin) begin
         @(negedge clk);
         if (host_req && last_act == cyc - 1) host_req = 1'b0;
         #3;
         if (host_wait) waits++;
      end
   endtask

   task automatic do_read(input int row, input int col);
      int a, w;
      @(negedge clk);
      host_req = 1'b1; host_addr = {13'(row), 9'(col)};
      #3;
      a = cyc;
      chk(cmd_b == 4'b0011, "R1 activate code", cmd_b, 3);
      chk(!host_wait, "R8 free request not stalled", host_wait, 0);
      chk(sd_addr == 13'(row), "R7 row on activate", sd_addr, row);
      hold_req(a + 10, w);
      chk(last_rd == a + 3, "R7 read after tRCD", last_rd - a, 3);
      chk(m_col == (13'(col) | 13'h400), "R7 column with bit10", m_col, col | 1024);
      chk(last_rv == a + 6, "R7 rvalid cycle", last_rv - a, 6);
      chk(last_rvd == exp_data(row, col), "R7 read data", last_rvd, exp_data(row, col));
      chk(w == 0, "R8 no wait after activate", w, 0);
   endtask

   initial begin
      int p, p1, p2, a, b, w, w1;
      rst_n = 1'b0; cfg_interval = '0; host_req = 1'b0; host_addr = '0; stat_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #3;
      chk(cmd_b == 4'b0111, "R1 reset NOP", cmd_b, 7);
      chk(!host_wait && !host_rvalid && !ref_irq && stat_rdata == 2'b00, "R1 reset outputs",
          {host_wait, host_rvalid, ref_irq, stat_rdata}, 0);

      // R4: disabled refresh
      repeat (100) @(negedge clk);
      #3;
      chk(pre_cnt == 0, "R4 no refresh when period zero", pre_cnt, 0);
      chk(!ref_irq, "R4 no error when period zero", ref_irq, 0);

      // R7 / R8: read sweep
      for (int i = 0; i < 6; i++) begin
         int row, col;
         row = (i == 5) ? 8191 : (i * 2731) % 8192;
         col = (i == 4) ? 511 : (i * 97 + 3) % 512;
         do_read(row, col);
      end

      // R9: back-to-back requests
      @(negedge clk);
      host_req = 1'b1; host_addr = {13'd100, 9'd7};
      #3; a = cyc;
      @(negedge clk);
      host_addr = {13'd4321, 9'd300};
      #3;
      b = -1; w = 0;
      for (int k = 0; k < 20; k++) begin
         if (cmd_b == 4'b0011) begin b = cyc; break; end
         if (host_wait) w++;
         @(negedge clk); #3;
      end
      chk(b == a + 9, "R9 next activate spacing", b - a, 9);
      chk(w == 8, "R8 wait held until activate", w, 8);
      hold_req(b + 8, w1);
      chk(last_rv == b + 6 && last_rvd == exp_data(4321, 300), "R7 second read data", last_rvd, exp_data(4321, 300));

      // R2 / R3 / R11: period sweep
      for (int n = 12; n <= 17; n++) begin
         @(negedge clk); cfg_interval = '0;
         repeat (30) @(negedge clk);
         cfg_interval = 16'(n);
         wait_cmd(4'b0010, n + 20, p1);
         chk(pre_a10 == 1'b1, "R3 precharge bit10 high", pre_a10, 1);
         wait_cmd(4'b0010, n + 20, p2);
         chk(p1 > 0 && p2 - p1 == n, "R2 refresh spacing", p2 - p1, n);
         chk(last_ref == p1 + 3, "R3 auto-refresh after tRP", last_ref - p1, 3);
         if (n == 12) begin
            @(negedge clk); #3;
            chk(stat_rdata[1] == 1'b1, "R11 busy during refresh", stat_rdata[1], 1);
         end
      end
      chk(!ref_irq, "R5 no error at period 12 or more", ref_irq, 0);

      // R10: refresh priority and ordering
      @(negedge clk); cfg_interval = '0;
      repeat (30) @(negedge clk);
      cfg_interval = 16'd40;
      wait_cmd(4'b0010, 60, p);
      @(negedge clk);
      host_req = 1'b1; host_addr = {13'd55, 9'd66};
      #3;
      chk(host_wait, "R8 wait during refresh", host_wait, 1);
      hold_req(p + 36, w1);
      chk(last_act == p + 11, "R3 activate after tRC", last_act - p, 11);
      chk(w1 == 9, "R8 wait until activate", w1 + 1, 10);
      chk(last_rv == p + 17 && last_rvd == exp_data(55, 66), "R7 read after refresh", last_rvd, exp_data(55, 66));
      @(negedge clk);
      host_req = 1'b1; host_addr = {13'd777, 9'd88};
      #3;
      chk(cmd_b == 4'b0011 && !host_wait, "R8 activate just before expiry", cmd_b, 3);
      hold_req(p + 43, w1);
      chk(last_rv == p + 43 && last_rvd == exp_data(777, 88), "R10 read in progress completes", last_rv - p, 43);
      @(negedge clk);
      host_req = 1'b1; host_addr = {13'd999, 9'd1};
      #3;
      chk(host_wait, "R8 wait during recovery", host_wait, 1);
      hold_req(p + 70, w1);
      chk(last_pre == p + 47, "R10 owed refresh wins", last_pre - p, 47);
      chk(last_act == p + 58, "R10 request served after refresh", last_act - p, 58);
      chk(w1 == 13, "R8 wait count behind refresh", w1, 13);
      chk(last_rv == p + 64 && last_rvd == exp_data(999, 1), "R7 read after priority", last_rvd, exp_data(999, 1));

      // R5 / R6: error flag
      @(negedge clk); cfg_interval = '0;
      repeat (30) @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0; #3;
      chk(!ref_irq, "R6 read with no error", ref_irq, 0);
      @(negedge clk); cfg_interval = 16'd6;
      b = -1;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk); #3;
         if (ref_irq) begin b = cyc; break; end
      end
      chk(b > 0, "R5 error on backlog period 6", ref_irq, 1);
      @(negedge clk); cfg_interval = '0;
      repeat (40) @(negedge clk);
      #3;
      chk(ref_irq && stat_rdata[0], "R5 error sticky", ref_irq, 1);
      @(negedge clk); stat_rd = 1'b1; #3;
      chk(stat_rdata[0] == 1'b1, "R6 status shows error on read", stat_rdata[0], 1);
      @(negedge clk); stat_rd = 1'b0; #3;
      chk(!ref_irq, "R6 read clears error", ref_irq, 1'b0);
      repeat (30) @(negedge clk);
      #3;
      chk(!ref_irq, "R6 error stays clear", ref_irq, 0);
      @(negedge clk); cfg_interval = 16'd11;
      b = -1;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk); #3;
         if (ref_irq) begin b = cyc; break; end
      end
      chk(b > 0, "R5 error on backlog period 11", ref_irq, 1);
      @(negedge clk); cfg_interval = '0;
      repeat (20) @(negedge clk);
      p = pre_cnt;
      repeat (100) @(negedge clk);
      #3;
      chk(pre_cnt == p, "R4 refresh stops when disabled", pre_cnt - p, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule